// File: doc/BRIEF.md
# Per-Interrupt Enable and Trigger Register Bank

This block keeps, for a parameterised number of interrupt IDs, the enable bit and the trigger mode (edge or level) of every interrupt. Software reaches it over a simple 32-bit register port. Writing a one into the set-enable window turns an interrupt on, and writing a one into the clear-enable window turns it off. A separate configuration window holds two bits for each interrupt. IDs below 32 are private: each requesting CPU has its own copy of their enable bits. IDs from 32 upward have one shared copy.

The bank also watches the level of every interrupt input. Suppose software enables an interrupt that is configured level-sensitive while its input is already high. The bank then emits a one-cycle pending-set pulse for that interrupt, so a downstream pending store does not miss a level that rose while the interrupt was masked. The bank drives the enable vectors and the pulses to the rest of the interrupt controller. It does no prioritisation and no delivery.

Top module: `irq_enable_bank`

## Requirements
- R1: A write to the set-enable window (byte offsets 0x100 to 0x17F; word n covers IDs 32n to 32n+31, data bit i is ID 32n+i) sets the enable of every ID whose data bit is one. Enables whose data bit is zero keep their value.
- R2: A write to the clear-enable window (0x180 to 0x1FF, same bit layout as R1) clears the enable of every ID whose data bit is one. All other enables are left unchanged.
- R3: A read of either enable window returns the current enable bits in the layout of R1. For word 0 these are the bits of the requesting CPU.
- R4: Enable writes aimed at IDs 0 to 15 have no effect. Those enables always read zero.
- R5: A set-enable write to an ID whose trigger mode is level and whose `irq_level` input is high produces a single-cycle pulse on that ID's pending output. The pulse appears in the cycle after the write is accepted. An edge-configured ID, or an ID whose input is low, gives no pulse.
- R6: The configuration window starts at 0xC00. Word n covers IDs 16n to 16n+15. For ID 16n+k, bit 2k+1 is the trigger mode (1 = edge, 0 = level) and bit 2k is reserved and reads zero. After reset, IDs 16 and up are level.
- R7: IDs 0 to 15 are always edge. Configuration writes cannot clear their mode bits, and after reset word 0 reads 0xAAAAAAAA.
- R8: Writes to enable or configuration words whose IDs are all at or above NUM_IRQ change nothing, and reads of such words return zero.
- R9: Enable bits of IDs below 32 are banked per requesting CPU (`req_cpu`). One CPU's writes never change another CPU's private bits. IDs 32 and up are shared.
- R10: On a write, each byte lane of `req_wdata` takes effect only when its bit in `req_be` is set (lane b is bits 8b+7 to 8b).
- R11: A read accepted at a clock edge returns its data with `rsp_valid` high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the 32-bit word |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte-lane write strobes |
| req_cpu | input | CPU_W | Index of the requesting CPU |
| irq_level | input | NUM_IRQ | Current level of each interrupt input |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| en_priv | output | NUM_CPU*32 | Private enables, CPU c in bits 32c+31 to 32c |
| en_shared | output | NUM_IRQ-32 | Shared enables, bit j is ID 32+j |
| pend_priv | output | NUM_CPU*32 | Pending-set pulses for private IDs, laid out as en_priv |
| pend_shared | output | NUM_IRQ-32 | Pending-set pulses for shared IDs |

## Verification
The bench targets the corners where a slip stays hidden until software relies on it. Enabling through the set window with one-bits on the software-generated IDs must leave them off; a bank that honours them would read back 0xFFFFFFFF instead of 0xFFFF0000. Writes from the second CPU must not appear in the first CPU's private word, and a narrow byte strobe must touch only its lane. Two further probes cover the configuration window: an all-ones write must read back with the reserved even bits at zero, and an all-zeros write to word 0 must still read as edge. The pending pulse is checked on the exact cycle and on the cycle after it, for a level ID with its input high, an edge ID with its input high, and a level ID with its input low. A design that pulsed for the wrong mode, or held the pulse high, would fail there.

// File: rtl/irqbank_pkg.sv
// Shared constants and types of the interrupt enable/trigger bank.
// Assumes 32-bit register words and a 12-bit byte offset space.
package irqbank_pkg;
    localparam int unsigned ADDR_W   = 12;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned BE_W     = DATA_W / 8;
    localparam int unsigned PRIV_IDS = 32;   // IDs banked per CPU
    localparam int unsigned SWGEN_IDS = 16;  // software-generated IDs
    localparam int unsigned WORD_W   = 6;    // word index inside a window

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_SET  = 2'd1,
        WIN_CLR  = 2'd2,
        WIN_CFG  = 2'd3
    } win_e;
endpackage

// File: rtl/irqbank_decode.sv
// Address decoder: maps a byte offset onto one of the register windows
// and the word index inside it. Assumes word-aligned offsets; an
// unaligned offset selects no window.
module irqbank_decode
    import irqbank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output win_e              win,
    output logic [WORD_W-1:0] word
);
    localparam logic [4:0] SET_PAGE = 5'h02;  // 0x100 >> 7
    localparam logic [4:0] CLR_PAGE = 5'h03;  // 0x180 >> 7
    localparam logic [3:0] CFG_PAGE = 4'hC;   // 0xC00 >> 8

    // Purpose: choose the window and extract the word index.
    always_comb begin
        win  = WIN_NONE;
        word = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr[11:7] == SET_PAGE) begin
                win  = WIN_SET;
                word = {1'b0, addr[6:2]};
            end else if (addr[11:7] == CLR_PAGE) begin
                win  = WIN_CLR;
                word = {1'b0, addr[6:2]};
            end else if (addr[11:8] == CFG_PAGE) begin
                win  = WIN_CFG;
                word = addr[7:2];
            end
        end
    end
endmodule

// File: rtl/irqbank_trigcfg.sv
// Trigger-mode store: one edge/level bit per interrupt, two register
// bits per ID (odd bit = mode, even bit reserved). IDs below 16 are
// held at edge. Assumes NUM_IRQ is a multiple of 32.
module irqbank_trigcfg
    import irqbank_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] word,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BE_W-1:0]   be,
    output logic [NUM_IRQ-1:0] edge_cfg,
    output logic [DATA_W-1:0] rd_word
);
    localparam int unsigned IDS_PER_WORD = DATA_W / 2;
    localparam int unsigned IDS_PER_LANE = IDS_PER_WORD / BE_W;

    logic [NUM_IRQ-1:0] edge_q;
    logic [NUM_IRQ-1:0] hit;
    logic [NUM_IRQ-1:0] new_mode;

    // Per-ID write select and incoming mode bit.
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_id
        localparam int unsigned W    = g / IDS_PER_WORD;
        localparam int unsigned K    = g % IDS_PER_WORD;
        localparam int unsigned LANE = K / IDS_PER_LANE;
        localparam bit          SWG  = (g < SWGEN_IDS);
        assign hit[g]      = wr_en && (word == WORD_W'(W)) && be[LANE];
        assign new_mode[g] = wdata[2*K+1] | SWG;
    end

    // Purpose: hold the trigger mode of every ID.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NUM_IRQ); i++)
                edge_q[i] <= (i < int'(SWGEN_IDS));
        end else begin
            for (int i = 0; i < int'(NUM_IRQ); i++)
                if (hit[i]) edge_q[i] <= new_mode[i];
        end
    end

    // Purpose: present the addressed word with reserved bits at zero.
    always_comb begin
        rd_word = '0;
        for (int k = 0; k < int'(IDS_PER_WORD); k++) begin
            if (int'(word) * int'(IDS_PER_WORD) + k < int'(NUM_IRQ))
                rd_word[2*k+1] = edge_q[int'(word) * int'(IDS_PER_WORD) + k];
        end
    end

    assign edge_cfg = edge_q;
endmodule

// File: rtl/irqbank_enable.sv
// Enable store: private enables banked per CPU for IDs below 32, one
// shared copy for the rest, and the pending-set pulse raised when a
// level-sensitive ID with a high input is enabled. Assumes NUM_IRQ is
// a multiple of 32 and greater than 32.
module irqbank_enable
    import irqbank_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64,
    parameter int unsigned NUM_CPU = 2,
    parameter int unsigned CPU_W   = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_set,
    input  logic                      wr_clr,
    input  logic [WORD_W-1:0]         word,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [BE_W-1:0]           be,
    input  logic [CPU_W-1:0]          cpu,
    input  logic [NUM_IRQ-1:0]        edge_cfg,
    input  logic [NUM_IRQ-1:0]        irq_level,
    output logic [NUM_CPU*PRIV_IDS-1:0] en_priv,
    output logic [NUM_IRQ-PRIV_IDS-1:0] en_shared,
    output logic [NUM_CPU*PRIV_IDS-1:0] pend_priv,
    output logic [NUM_IRQ-PRIV_IDS-1:0] pend_shared,
    output logic [DATA_W-1:0]         rd_word
);
    localparam int unsigned NUM_SHR = NUM_IRQ - PRIV_IDS;
    localparam int unsigned NWORDS  = NUM_IRQ / DATA_W;

    logic [NUM_IRQ-1:0]          hit;      // data bit one, lane on, ID writable
    logic [NUM_IRQ-1:0]          lvl_arm;  // level mode and input high
    logic [NUM_CPU*PRIV_IDS-1:0] priv_q, ppend_q;
    logic [NUM_SHR-1:0]          shr_q, spend_q;
    logic [NUM_CPU-1:0]          cpu_sel;
    logic [PRIV_IDS-1:0]         priv_view;

    // Per-ID write match.
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_id
        localparam int unsigned W    = g / DATA_W;
        localparam int unsigned B    = g % DATA_W;
        localparam int unsigned LANE = B / 8;
        localparam bit          WRT  = (g >= SWGEN_IDS);
        assign hit[g]     = WRT && (word == WORD_W'(W)) && be[LANE] && wdata[B];
        assign lvl_arm[g] = !edge_cfg[g] && irq_level[g];
    end

    // One-hot decode of the requesting CPU.
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        assign cpu_sel[c] = (cpu == CPU_W'(c));
    end

    // Purpose: banked private enables and their pending pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_q  <= '0;
            ppend_q <= '0;
        end else begin
            for (int c = 0; c < int'(NUM_CPU); c++) begin
                for (int b = 0; b < int'(PRIV_IDS); b++) begin
                    if (wr_set && cpu_sel[c] && hit[b])
                        priv_q[c*PRIV_IDS+b] <= 1'b1;
                    else if (wr_clr && cpu_sel[c] && hit[b])
                        priv_q[c*PRIV_IDS+b] <= 1'b0;
                    ppend_q[c*PRIV_IDS+b] <= wr_set && cpu_sel[c] && hit[b] && lvl_arm[b];
                end
            end
        end
    end

    // Purpose: shared enables and their pending pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shr_q   <= '0;
            spend_q <= '0;
        end else begin
            for (int j = 0; j < int'(NUM_SHR); j++) begin
                if (wr_set && hit[j+PRIV_IDS])
                    shr_q[j] <= 1'b1;
                else if (wr_clr && hit[j+PRIV_IDS])
                    shr_q[j] <= 1'b0;
                spend_q[j] <= wr_set && hit[j+PRIV_IDS] && lvl_arm[j+PRIV_IDS];
            end
        end
    end

    // Purpose: pick the requesting CPU's private word.
    always_comb begin
        priv_view = '0;
        for (int c = 0; c < int'(NUM_CPU); c++)
            if (cpu_sel[c]) priv_view = priv_q[c*PRIV_IDS +: PRIV_IDS];
    end

    // Purpose: present the addressed enable word, zero beyond NUM_IRQ.
    always_comb begin
        rd_word = '0;
        if (word == '0)
            rd_word = priv_view;
        else if (int'(word) < int'(NWORDS))
            rd_word = shr_q[(int'(word) - 1) * int'(DATA_W) +: DATA_W];
    end

    assign en_priv     = priv_q;
    assign en_shared   = shr_q;
    assign pend_priv   = ppend_q;
    assign pend_shared = spend_q;
endmodule

// File: rtl/irq_enable_bank.sv
// Top of the interrupt enable/trigger bank. Accepts one register
// access per cycle, updates state at the accepting edge and returns
// read data one cycle later. Assumes NUM_IRQ is a multiple of 32 and
// above 32; level inputs of private IDs are common to all CPUs.
module irq_enable_bank
    import irqbank_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64,
    parameter int unsigned NUM_CPU = 2,
    parameter int unsigned CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [11:0]                 req_addr,
    input  logic [31:0]                 req_wdata,
    input  logic [3:0]                  req_be,
    input  logic [CPU_W-1:0]            req_cpu,
    input  logic [NUM_IRQ-1:0]          irq_level,
    output logic                        rsp_valid,
    output logic [31:0]                 rsp_rdata,
    output logic [NUM_CPU*32-1:0]       en_priv,
    output logic [NUM_IRQ-33:0]         en_shared,
    output logic [NUM_CPU*32-1:0]       pend_priv,
    output logic [NUM_IRQ-33:0]         pend_shared
);
    win_e              win;
    logic [WORD_W-1:0] word;
    logic              do_wr, do_rd;
    logic [NUM_IRQ-1:0] edge_cfg;
    logic [DATA_W-1:0] en_rd, cfg_rd, rd_mux;

    assign do_wr = req_valid && req_write;
    assign do_rd = req_valid && !req_write;

    irqbank_decode u_decode (
        .addr (req_addr),
        .win  (win),
        .word (word)
    );

    irqbank_trigcfg #(.NUM_IRQ(NUM_IRQ)) u_trigcfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (do_wr && win == WIN_CFG),
        .word     (word),
        .wdata    (req_wdata),
        .be       (req_be),
        .edge_cfg (edge_cfg),
        .rd_word  (cfg_rd)
    );

    irqbank_enable #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_enable (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_set      (do_wr && win == WIN_SET),
        .wr_clr      (do_wr && win == WIN_CLR),
        .word        (word),
        .wdata       (req_wdata),
        .be          (req_be),
        .cpu         (req_cpu),
        .edge_cfg    (edge_cfg),
        .irq_level   (irq_level),
        .en_priv     (en_priv),
        .en_shared   (en_shared),
        .pend_priv   (pend_priv),
        .pend_shared (pend_shared),
        .rd_word     (en_rd)
    );

    // Purpose: select read data by window.
    always_comb begin
        case (win)
            WIN_SET, WIN_CLR: rd_mux = en_rd;
            WIN_CFG:          rd_mux = cfg_rd;
            default:          rd_mux = '0;
        endcase
    end

    // Purpose: register the read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= do_rd;
            rsp_rdata <= do_rd ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/irqbank_checker.sv
// Assertion checker for irq_enable_bank, attached by bind below.
module irqbank_checker #(
    parameter int unsigned NUM_IRQ = 64,
    parameter int unsigned NUM_CPU = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_write,
    input logic                  rsp_valid,
    input logic [NUM_CPU*32-1:0] en_priv,
    input logic [NUM_IRQ-33:0]   en_shared,
    input logic [NUM_CPU*32-1:0] pend_priv,
    input logic [NUM_IRQ-33:0]   pend_shared
);
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        AST_SWGEN_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            en_priv[c*32 +: 16] == '0);  // R4
        AST_PRIV_PULSE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
            ((pend_priv[c*32 +: 32] & ~en_priv[c*32 +: 32]) == '0));  // R5
    end

    AST_SHR_PULSE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_shared & ~en_shared) == '0));  // R5

    AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_shared || |pend_priv) |-> $past(req_valid && req_write));  // R5

    AST_ENABLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid && req_write) |-> ($stable(en_shared) && $stable(en_priv)));  // R1

    AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));  // R11

    AST_READ_GETS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);  // R11
endmodule

bind irq_enable_bank irqbank_checker #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .rsp_valid   (rsp_valid),
    .en_priv     (en_priv),
    .en_shared   (en_shared),
    .pend_priv   (pend_priv),
    .pend_shared (pend_shared)
);

// File: tb/irq_enable_bank_bench.sv
// Scoreboard bench: read tasks queue expected data, a monitor compares
// responses; pending pulses are sampled directly.
module irq_enable_bank_bench;
    localparam int unsigned NUM_IRQ = 64;
    localparam int unsigned NUM_CPU = 2;
    localparam int unsigned CPU_W   = 1;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  req_valid = 1'b0;
    logic                  req_write = 1'b0;
    logic [11:0]           req_addr = '0;
    logic [31:0]           req_wdata = '0;
    logic [3:0]            req_be = '0;
    logic [CPU_W-1:0]      req_cpu = '0;
    logic [NUM_IRQ-1:0]    irq_level = '0;
    logic                  rsp_valid;
    logic [31:0]           rsp_rdata;
    logic [NUM_CPU*32-1:0] en_priv;
    logic [NUM_IRQ-33:0]   en_shared;
    logic [NUM_CPU*32-1:0] pend_priv;
    logic [NUM_IRQ-33:0]   pend_shared;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;  // 250 MHz

    irq_enable_bank #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_irq_enable_bank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_cpu(req_cpu), .irq_level(irq_level), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .en_priv(en_priv), .en_shared(en_shared),
        .pend_priv(pend_priv), .pend_shared(pend_shared)
    );

    task automatic check64(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d,
                      input logic [3:0] be, input logic [CPU_W-1:0] c);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a;
        req_wdata = d; req_be = be; req_cpu = c;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [CPU_W-1:0] c,
                      input logic [31:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_cpu = c;
        e.data = exp; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare each response against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11: unexpected response actual=%h expected=none", rsp_rdata);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check64({32'h0, rsp_rdata}, {32'h0, e.data}, e.tag);
            end
        end
    end

    initial begin
        #800000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state
        rd(12'h104, 0, 32'h0, "R3 reset shared enables");
        rd(12'hC00, 0, 32'hAAAAAAAA, "R7 reset swgen edge");
        rd(12'hC04, 0, 32'h0, "R6 reset level");
        // Set and clear
        wr(12'h104, 32'h5, 4'hF, 0);
        rd(12'h104, 0, 32'h5, "R1 set window");
        rd(12'h184, 0, 32'h5, "R3 clear window read");
        wr(12'h104, 32'h0, 4'hF, 0);
        rd(12'h104, 0, 32'h5, "R1 zero bits keep");
        wr(12'h184, 32'h1, 4'hF, 0);
        rd(12'h104, 0, 32'h4, "R2 clear window");
        // Byte strobes
        wr(12'h104, 32'hFFFFFF00, 4'b0100, 0);
        rd(12'h104, 0, 32'h00FF0004, "R10 single lane");
        // Software-generated IDs and banking
        wr(12'h100, 32'hFFFFFFFF, 4'hF, 0);
        rd(12'h100, 0, 32'hFFFF0000, "R4 swgen ignored");
        rd(12'h100, 1, 32'h0, "R9 cpu1 untouched");
        wr(12'h100, 32'h00030000, 4'hF, 1);
        rd(12'h100, 1, 32'h00030000, "R9 cpu1 own bank");
        rd(12'h100, 0, 32'hFFFF0000, "R9 cpu0 unaffected");
        wr(12'h180, 32'hFFFFFFFF, 4'hF, 0);
        rd(12'h100, 0, 32'h0, "R2 cpu0 private clear");
        rd(12'h180, 1, 32'h00030000, "R9 cpu1 survives clear");
        // Out of range
        wr(12'h108, 32'hFFFFFFFF, 4'hF, 0);
        rd(12'h108, 0, 32'h0, "R8 enable beyond count");
        rd(12'h104, 0, 32'h00FF0004, "R8 in-range unchanged");
        wr(12'hC10, 32'hFFFFFFFF, 4'hF, 0);
        rd(12'hC10, 0, 32'h0, "R8 config beyond count");
        // Configuration window
        wr(12'hC08, 32'hFFFFFFFF, 4'hF, 0);
        rd(12'hC08, 0, 32'hAAAAAAAA, "R6 reserved bits zero");
        wr(12'hC08, 32'h00000008, 4'hF, 0);
        rd(12'hC08, 0, 32'h00000008, "R6 ID33 edge only");
        wr(12'hC00, 32'h0, 4'hF, 0);
        rd(12'hC00, 0, 32'hAAAAAAAA, "R7 swgen stays edge");
        // Pending pulses
        wr(12'h184, 32'hFFFFFFFF, 4'hF, 0);
        irq_level[40] = 1'b1;
        irq_level[33] = 1'b1;
        irq_level[20] = 1'b1;
        wr(12'h104, 32'h00000102, 4'hF, 0);
        check64({32'h0, pend_shared}, 64'h100, "R5 level high pulses, edge does not");
        @(negedge clk);
        check64({32'h0, pend_shared}, 64'h0, "R5 pulse one cycle");
        wr(12'h100, 32'h00100000, 4'hF, 1);
        check64(pend_priv, 64'h1 << (32 + 20), "R5 R9 private pulse to cpu1");
        @(negedge clk);
        check64(pend_priv, 64'h0, "R5 private pulse ends");
        wr(12'h104, 32'h00000200, 4'hF, 0);
        check64({32'h0, pend_shared}, 64'h0, "R5 level low no pulse");
        check64({32'h0, en_shared}, 64'h302, "R1 enable outputs");
        repeat (3) @(negedge clk);
        check64(64'(sb_q.size()), 64'h0, "R11 all reads answered");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule